// File: doc/BRIEF.md
# Banked GPIO Register File

This block is a memory-mapped general-purpose pin controller. It holds a parameterised number of 32-pin banks behind a plain 32-bit register bus. Each bank has its own direction register and output latch. Each bank also presents the sampled level of its pins. The block drives a value and an output enable for every pin, and it samples every pin through a synchronizer before software can read it.

Software changes output bits in one of three ways. It can write the whole latch, write ones to a set word, or write ones to a clear word. Set and clear touch only the selected bits, so no read-modify-write is needed. A direction bit of 1 makes its pin an input and releases the output enable. The latch still drives the pin's value line while the pin is an input, so a level can be staged before the pin is turned around.

Bank b starts at byte address 0x10 + 0x28*b. Inside each bank the words sit at consecutive 4-byte steps: direction, output latch, set, clear, input. The five words after these are reserved for edge and interrupt functions, which this block does not implement.

Writes take effect at the clock edge where the write enable is high. A read issued at one edge returns its data, together with a one-cycle `bus_rd_valid` pulse, at the next edge. The read path has no back-pressure: the requester must take the data in the cycle in which `bus_rd_valid` is high. `bus_rd_data` then holds its value until the next read.

Top module: `gpio_bankfile`

## Requirements
- R1: After reset every direction bit is 1 and every latch bit is 0. So pin_oe and pin_out are all 0, bus_rd_valid is 0, and the direction word reads 0xFFFFFFFF.
- R2: Writing the direction word (bank offset 0x00) replaces it. pin_oe for a bit is 1 exactly when its direction bit is 0, and the word reads back as written.
- R3: Writing the set word (offset 0x08) ORs the write data into the latch: 1 bits set latch bits and 0 bits leave them unchanged. Reading the set word returns the latch.
- R4: Writing the clear word (offset 0x0C) clears the latch bits where the data is 1 and leaves the others unchanged. Reading the clear word returns the latch.
- R5: Writing the output word (offset 0x04) replaces the whole latch, and reading it returns the latch.
- R6: The input word (offset 0x10) returns the pin level after a two-flop synchronizer, including for pins configured as outputs. A pin change made before clock edge E is returned by a read sampled at edge E+2 but not by one sampled at edge E+1.
- R7: Bank b decodes at base 0x10 + 0x28*b, and bank b owns pins 32*b to 32*b+31. An access to one bank leaves every other bank's direction and latch unchanged.
- R8: Reads of any address outside the five decoded words of each bank return 0, including the bank's reserved words at offsets 0x14 to 0x24. Writes there change no direction or latch bit.
- R9: When bus_rd_en is high at an edge, bus_rd_valid is high for exactly the following cycle and bus_rd_data carries the addressed word. Otherwise bus_rd_valid is low and bus_rd_data holds its last value.
- R10: pin_out always shows the latch, whatever the direction, and it changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe for this cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read request for this cycle |
| bus_rd_data | output | 32 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | One-cycle pulse marking returned read data |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Output latch value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin, 1 drives the pin |

## Verification
The bench builds the block with its defaults: NUM_BANKS=5, ADDR_W=8 and SYNC_STAGES=2. Five banks bring the last base address 0xB0 within reach, along with the first address past the decoded space (0xD8), so bank isolation can be seen across the full map. With two synchronizer stages, a read one edge after a pin change still returns the stale level, and a read one edge later returns the new one.

// File: rtl/gpio_bankfile_pkg.sv
package gpio_bankfile_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int BANK_BASE     = 'h10;
  localparam int BANK_STRIDE   = 'h28;
  localparam int DECODED_WORDS = 5;

  // word index inside a bank; order fixes the address layout
  typedef enum int {
    WD_DIR = 0,
    WD_OUT = 1,
    WD_SET = 2,
    WD_CLR = 3,
    WD_IN  = 4
  } bank_word_e;

  function automatic int word_addr(int bank, int word);
    return BANK_BASE + bank * BANK_STRIDE + 4 * word;
  endfunction
endpackage

// File: rtl/gpio_bankfile_sync.sv
module gpio_bankfile_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bankfile_slice.sv
module gpio_bankfile_slice
  import gpio_bankfile_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_IDX = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic [PINS_PER_BANK-1:0] pin_level,
  output logic [PINS_PER_BANK-1:0] dir_q,
  output logic [PINS_PER_BANK-1:0] latch_q,
  output logic                     rd_hit,
  output logic [31:0]              rd_word
);
  logic [DECODED_WORDS-1:0] sel;

  always_comb begin
    for (int w = 0; w < DECODED_WORDS; w++)
      sel[w] = (addr == ADDR_W'(word_addr(BANK_IDX, w)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      latch_q <= '0;
    end else if (wr_en) begin
      if (sel[WD_DIR]) dir_q   <= wr_data;
      if (sel[WD_OUT]) latch_q <= wr_data;
      if (sel[WD_SET]) latch_q <= latch_q | wr_data;
      if (sel[WD_CLR]) latch_q <= latch_q & ~wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel[WD_DIR]) rd_word = dir_q;
    if (sel[WD_OUT] || sel[WD_SET] || sel[WD_CLR]) rd_word = latch_q;
    if (sel[WD_IN]) rd_word = pin_level;
  end

  assign rd_hit = |sel;
endmodule

// File: rtl/gpio_bankfile.sv
module gpio_bankfile
  import gpio_bankfile_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_wr_en,
  input  logic [31:0]                        bus_wr_data,
  input  logic                               bus_rd_en,
  output logic [31:0]                        bus_rd_data,
  output logic                               bus_rd_valid,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_oe
);
  localparam int NUM_PINS = NUM_BANKS * PINS_PER_BANK;

  logic [NUM_PINS-1:0] pin_sync;
  logic [31:0]         bank_word [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic [31:0]         rd_mux;

  gpio_bankfile_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PINS_PER_BANK-1:0] dir_b;
    logic [PINS_PER_BANK-1:0] latch_b;

    gpio_bankfile_slice #(.ADDR_W(ADDR_W), .BANK_IDX(b)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr_en    (bus_wr_en),
      .wr_data  (bus_wr_data),
      .pin_level(pin_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir_q    (dir_b),
      .latch_q  (latch_b),
      .rd_hit   (bank_hit[b]),
      .rd_word  (bank_word[b])
    );

    assign pin_out[b*PINS_PER_BANK +: PINS_PER_BANK] = latch_b;
    assign pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]  = ~dir_b;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_hit[b]) rd_mux = rd_mux | bank_word[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rd_data  <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) bus_rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bankfile_chk.sv
module gpio_bankfile_chk
  import gpio_bankfile_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [ADDR_W-1:0]                  bus_addr,
  input logic                               bus_wr_en,
  input logic [31:0]                        bus_wr_data,
  input logic                               bus_rd_en,
  input logic                               bus_rd_valid,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_out,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_oe
);
  localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(word_addr(0, WD_SET));
  localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(word_addr(0, WD_CLR));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !bus_rd_valid));

  a_r3_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == SET0) |=>
      pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wr_data)));

  a_r4_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == CLR0) |=>
      pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wr_data)));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rd_valid);

  a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pin_oe));

  a_r10_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pin_out));
endmodule

bind gpio_bankfile gpio_bankfile_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_data (bus_wr_data),
  .bus_rd_en   (bus_rd_en),
  .bus_rd_valid(bus_rd_valid),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe)
);

// File: tb/sim_gpio_bankfile.sv
module sim_gpio_bankfile;
  localparam int NB = 5;
  localparam int AW = 8;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [31:0]   bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [31:0]   bus_rd_data;
  logic          bus_rd_valid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_dir [NB];
  logic [31:0] m_lat [NB];

  always #10 clk = ~clk;

  gpio_bankfile #(.NUM_BANKS(NB), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .bus_rd_valid(bus_rd_valid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [AW-1:0] ra(int bank, int word);
    return AW'('h10 + 'h28 * bank + 4 * word);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag);
    for (int b = 0; b < NB; b++) begin
      check({tag, " oe"}, pin_oe[b*32 +: 32], ~m_dir[b]);
      check({tag, " out"}, pin_out[b*32 +: 32], m_lat[b]);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  // monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unrequested valid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), bus_rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_lat[b] = '0; end
    repeat (3) @(negedge clk);
    check_pins("R1 reset");
    check("R1 rd_valid in reset", {31'b0, bus_rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(ra(0, 0), 32'hFFFF_FFFF, "R1 dir reset");
    bus_read(ra(3, 1), 32'h0, "R1 latch reset");

    // R2 direction
    bus_write(ra(0, 0), 32'hFFFF_0000); m_dir[0] = 32'hFFFF_0000;
    check_pins("R2 dir write");
    bus_read(ra(0, 0), 32'hFFFF_0000, "R2 dir readback");

    // R5 whole latch write
    bus_write(ra(0, 1), 32'h1234_5678); m_lat[0] = 32'h1234_5678;
    check_pins("R5 latch write");
    bus_read(ra(0, 1), 32'h1234_5678, "R5 latch readback");

    // R3 set
    bus_write(ra(0, 2), 32'h0000_00F0); m_lat[0] = 32'h1234_56F8;
    check_pins("R3 set");
    bus_read(ra(0, 2), 32'h1234_56F8, "R3 set word reads latch");

    // R4 clear
    bus_write(ra(0, 3), 32'h1030_0008); m_lat[0] = 32'h0204_56F0;
    check_pins("R4 clear");
    bus_read(ra(0, 3), 32'h0204_56F0, "R4 clear word reads latch");

    // R10 latch drives while pin is input, R7 last bank
    bus_write(ra(4, 2), 32'h8000_0001); m_lat[4] = 32'h8000_0001;
    check_pins("R10 R7 bank4 set as input");

    // R7 middle bank direction only
    bus_write(ra(2, 0), 32'h0000_0000); m_dir[2] = 32'h0;
    check_pins("R7 bank2 dir");
    bus_read(ra(2, 0), 32'h0, "R7 bank2 dir readback");
    bus_read(ra(1, 0), 32'hFFFF_FFFF, "R7 bank1 untouched");

    // R6 synchronizer latency, output pins too
    pin_in[31:0]    = 32'hA5A5_A5A5;
    pin_in[159:128] = 32'h0F0F_0000;
    @(negedge clk);
    bus_read(ra(0, 4), 32'h0, "R6 stale one edge later");
    bus_read(ra(0, 4), 32'hA5A5_A5A5, "R6 new level two edges later");
    bus_read(ra(4, 4), 32'h0F0F_0000, "R6 bank4 input");

    // R8 unused addresses
    bus_read(ra(0, 5), 32'h0, "R8 reserved word");
    bus_read(ra(1, 9), 32'h0, "R8 reserved last word");
    bus_read(8'h00, 32'h0, "R8 below map");
    bus_read(8'hD8, 32'h0, "R8 past map");
    bus_write(ra(0, 6), 32'hFFFF_FFFF);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'h0);
    check_pins("R8 writes ignored");

    // R2 back to inputs, R10 latch kept
    bus_write(ra(0, 0), 32'hFFFF_FFFF); m_dir[0] = 32'hFFFF_FFFF;
    check_pins("R2 R10 release keeps latch");

    // R9 hold after idle
    bus_read(ra(0, 1), 32'h0204_56F0, "R9 last read");
    repeat (3) @(negedge clk);
    check("R9 data holds", bus_rd_data, 32'h0204_56F0);
    check("R9 valid low idle", {31'b0, bus_rd_valid}, 32'h0);
    check("R9 all reads returned", exp_q.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule